// File: doc/BRIEF.md
# Flash Program/Erase Protection Controller

This block decides whether the on-chip flash array may be programmed or erased, block by block, and raises an abort toward the flash sequencer when the processor misbehaves during such an operation. Software owns a small register set: a control byte with a write-enable bit, the program, erase and the two verify mode bits; an emulation flag that marks the flash as overlaid by RAM; and an erase-select mask with one bit per block, split into bytes.

The block watches three processor-side event lines: flash reads (data, vector or instruction fetch), exception entries other than reset, and sleep entry. If any of them fires while a program or erase operation is actually in effect, the abort output rises in that same cycle, the mode bit is dropped, and a sticky lock is set. The lock keeps program and erase out until a power-on reset. The other registers keep their values, and the verify modes stay usable. A warm reset clears the software registers but leaves the lock alone.

Top module: `flash_guard`

## Requirements
- R1: With the write-enable bit (control bit 6) at 0, pgmAllow, ersAllow, pgmActive and ersActive are all 0.
- R2: ersAllow[i] is 1 only when mask bit i is set (mask low byte at address 2, high byte at address 3), and ersActive is 0 whenever the whole mask is zero.
- R3: With the emulation flag (bit 0 at address 1) at 1, all four permission outputs are 0.
- R4: A flash read while pgmActive or ersActive is 1 raises abortReq in the same cycle and sets errLock (control bit 7) on the next clock edge.
- R5: An exception entry or a sleep event while pgmActive or ersActive is 1 has the same effect as R4.
- R6: When the lock is set, the program bit (control bit 0) and the erase bit (control bit 1) read back as 0. The write-enable bit, the verify bits and the mask keep their values.
- R7: While locked, writing 1 to the program or erase bit leaves it at 0, and pgmActive and ersActive stay 0.
- R8: While locked, the program-verify bit (control bit 2) and the erase-verify bit (control bit 3) can still be written and read back.
- R9: The lock is cleared only by porRstN. A software write of 0 to bit 7 and a warmRst pulse both leave it set, and warmRst does clear the mask.
- R10: Events that arrive while neither pgmActive nor ersActive is 1 raise no abort and leave the lock clear.
- R11: Reset state: all registers read 0, and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| warmRst | input | 1 | Synchronous non-power-on reset, clears the software registers only |
| regWe | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register address (0 control, 1 emulation, 2 and up mask bytes) |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr |
| flashRd | input | 1 | Processor reads flash this cycle |
| excEntry | input | 1 | Non-reset exception entry this cycle |
| sleepEvt | input | 1 | Sleep entry this cycle |
| pgmAllow | output | NBLK | Program permitted, per block |
| ersAllow | output | NBLK | Erase permitted, per block |
| pgmActive | output | 1 | Effective program mode to the sequencer |
| ersActive | output | 1 | Effective erase mode to the sequencer |
| abortReq | output | 1 | Abort request to the sequencer, combinational |
| errLock | output | 1 | Sticky error-protection state |

## Verification
The permission decode is swept over every combination of write-enable and emulation flag, crossed with an all-zero mask, an all-ones mask and each single walking-one mask. This separates the global gates from the per-block erase selection and catches the zero-mask special case. Each of the three event kinds is fired during program and during erase, from a fresh power-on reset each time, to tell the event sources and the two modes apart. After each lock, rewrites of the mode bits, writes to the verify bits, a software clear and a warm reset show which state survives. Events fired with the mode bits set but gated off confirm that only an effective operation is watched.

// File: rtl/fg_pkg.sv
package fg_pkg;
  typedef struct packed {
    logic wrCtrl;   // control byte write
    logic wrEmu;    // emulation flag write
    logic wrMask;   // some mask byte write (index decoded in datapath)
    logic abortNow; // error hit this cycle: drop mode bits
    logic warmClr;  // warm reset: clear software registers
  } fgStrobe_t;

  localparam int CTRL_ADDR = 0;
  localparam int EMU_ADDR  = 1;
  localparam int MASK_BASE = 2;
endpackage

// File: rtl/fg_ctrl.sv
module fg_ctrl
  import fg_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              warmRst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              modeActive,
  input  logic              flashRd,
  input  logic              excEntry,
  input  logic              sleepEvt,
  output fgStrobe_t         strb,
  output logic              abortReq,
  output logic              errLock
);
  logic errHit;

  assign errHit   = modeActive & (flashRd | excEntry | sleepEvt);
  assign abortReq = errHit;

  always_comb begin
    strb.wrCtrl   = regWe & (regAddr == ADDR_W'(CTRL_ADDR));
    strb.wrEmu    = regWe & (regAddr == ADDR_W'(EMU_ADDR));
    strb.wrMask   = regWe & (regAddr >= ADDR_W'(MASK_BASE));
    strb.abortNow = errHit;
    strb.warmClr  = warmRst;
  end

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN)    errLock <= 1'b0;
    else if (errHit) errLock <= 1'b1;
  end

  // R9: the lock never drops without power-on reset
  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!porRstN)
    errLock |=> errLock);
  // R4 / R5: a hit during an effective operation sets the lock
  p_hit_locks_r4: assert property (@(posedge clk) disable iff (!porRstN)
    (modeActive && (flashRd || excEntry || sleepEvt)) |=> errLock);
  // R10: no abort without an effective operation
  p_no_idle_abort_r10: assert property (@(posedge clk) disable iff (!porRstN)
    (!modeActive) |-> !abortReq);
endmodule

// File: rtl/fg_regs.sv
module fg_regs
  import fg_pkg::*;
#(
  parameter int NBLK   = 16,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              porRstN,
  input  fgStrobe_t         strb,
  input  logic              errLock,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  output logic [NBLK-1:0]   pgmAllow,
  output logic [NBLK-1:0]   ersAllow,
  output logic              pgmActive,
  output logic              ersActive,
  output logic              modeActive
);
  localparam int MASK_BYTES = (NBLK + 7) / 8;
  localparam int MASK_W     = MASK_BYTES * 8;

  logic pgmBit, ersBit, pgmVfy, ersVfy, swEn, emuOn;
  logic [MASK_W-1:0] maskReg;
  logic [NBLK-1:0]   blkSel;
  logic              gateOpen;

  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      pgmBit <= 1'b0; ersBit <= 1'b0; pgmVfy <= 1'b0;
      ersVfy <= 1'b0; swEn   <= 1'b0; emuOn  <= 1'b0;
    end else if (strb.warmClr) begin
      pgmBit <= 1'b0; ersBit <= 1'b0; pgmVfy <= 1'b0;
      ersVfy <= 1'b0; swEn   <= 1'b0; emuOn  <= 1'b0;
    end else begin
      if (strb.wrCtrl) begin
        pgmBit <= regWdata[0] & ~errLock & ~strb.abortNow;
        ersBit <= regWdata[1] & ~errLock & ~strb.abortNow;
        pgmVfy <= regWdata[2];
        ersVfy <= regWdata[3];
        swEn   <= regWdata[6];
      end else if (strb.abortNow) begin
        pgmBit <= 1'b0;
        ersBit <= 1'b0;
      end
      if (strb.wrEmu) emuOn <= regWdata[0];
    end
  end

  for (genvar b = 0; b < MASK_BYTES; b++) begin : g_mask
    always_ff @(posedge clk or negedge porRstN) begin
      if (!porRstN)           maskReg[b*8 +: 8] <= 8'h00;
      else if (strb.warmClr)  maskReg[b*8 +: 8] <= 8'h00;
      else if (strb.wrMask && regAddr == ADDR_W'(MASK_BASE + b))
                              maskReg[b*8 +: 8] <= regWdata;
    end
  end

  assign blkSel     = maskReg[NBLK-1:0];
  assign gateOpen   = swEn & ~emuOn & ~errLock;
  assign pgmAllow   = {NBLK{gateOpen}};
  assign ersAllow   = {NBLK{gateOpen}} & blkSel;
  assign pgmActive  = pgmBit & gateOpen;
  assign ersActive  = ersBit & gateOpen & (|blkSel);
  assign modeActive = pgmActive | ersActive;

  always_comb begin
    regRdata = 8'h00;
    if (regAddr == ADDR_W'(CTRL_ADDR))
      regRdata = {errLock, swEn, 2'b00, ersVfy, pgmVfy, ersBit, pgmBit};
    else if (regAddr == ADDR_W'(EMU_ADDR))
      regRdata = {7'b0, emuOn};
    for (int b = 0; b < MASK_BYTES; b++)
      if (regAddr == ADDR_W'(MASK_BASE + b)) regRdata = maskReg[b*8 +: 8];
  end

  // R6: an abort leaves both mode bits clear
  p_abort_drops_r6: assert property (@(posedge clk) disable iff (!porRstN)
    strb.abortNow |=> (!pgmBit && !ersBit));
  // R7: no operation runs while locked
  p_locked_idle_r7: assert property (@(posedge clk) disable iff (!porRstN)
    errLock |-> (!pgmActive && !ersActive));
  // R2: erase permission never exceeds the selection
  p_ers_subset_r2: assert property (@(posedge clk) disable iff (!porRstN)
    ((ersAllow & ~blkSel) == '0) && (ersActive -> (|blkSel)));
  // R3: emulation overlay shuts everything
  p_emu_block_r3: assert property (@(posedge clk) disable iff (!porRstN)
    emuOn |-> (pgmAllow == '0 && !pgmActive && !ersActive));
endmodule

// File: rtl/flash_guard.sv
module flash_guard
  import fg_pkg::*;
#(
  parameter int NBLK = 16,
  localparam int MASK_BYTES = (NBLK + 7) / 8,
  localparam int ADDR_W = $clog2(MASK_BYTES + 2)
) (
  input  logic              clk,
  input  logic              porRstN,
  input  logic              warmRst,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              flashRd,
  input  logic              excEntry,
  input  logic              sleepEvt,
  output logic [NBLK-1:0]   pgmAllow,
  output logic [NBLK-1:0]   ersAllow,
  output logic              pgmActive,
  output logic              ersActive,
  output logic              abortReq,
  output logic              errLock
);
  fgStrobe_t strb;
  logic      modeActive;

  fg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk, .porRstN, .warmRst, .regWe, .regAddr, .modeActive,
    .flashRd, .excEntry, .sleepEvt, .strb, .abortReq, .errLock
  );

  fg_regs #(.NBLK(NBLK), .ADDR_W(ADDR_W)) regs_i (
    .clk, .porRstN, .strb, .errLock, .regAddr, .regWdata, .regRdata,
    .pgmAllow, .ersAllow, .pgmActive, .ersActive, .modeActive
  );
endmodule

// File: tb/flash_guard_tb.sv
module flash_guard_tb_top;
  localparam int NBLK = 16;
  localparam int AW = 2;

  logic clk = 1'b0, porRstN = 1'b0, warmRst = 1'b0, regWe = 1'b0;
  logic [AW-1:0] regAddr = '0;
  logic [7:0] regWdata = 8'h00, regRdata;
  logic flashRd = 1'b0, excEntry = 1'b0, sleepEvt = 1'b0;
  logic [NBLK-1:0] pgmAllow, ersAllow;
  logic pgmActive, ersActive, abortReq, errLock;

  int nCmp = 0, nBad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  flash_guard #(.NBLK(NBLK)) dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk); regWe = 1'b1; regAddr = AW'(a); regWdata = d;
    @(negedge clk); regWe = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    regAddr = AW'(a); #0.5; d = regRdata;
  endtask

  task automatic por();
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk); @(negedge clk); porRstN = 1'b1;
  endtask

  initial begin
    logic [7:0] r;
    por();
    // R11 reset state
    rd(0, r); check("R11 ctrl", r, 0);
    rd(2, r); check("R11 mask", r, 0);
    check("R11 outs", {pgmAllow, ersAllow, pgmActive, ersActive, abortReq, errLock}, 0);

    // R1 R2 R3 sweep
    for (int sw = 0; sw < 2; sw++)
      for (int em = 0; em < 2; em++)
        for (int p = 0; p < NBLK + 2; p++) begin
          logic [NBLK-1:0] m;
          logic g;
          m = (p == 0) ? '0 : (p == 1) ? '1 : (NBLK'(1) << (p - 2));
          g = (sw == 1) && (em == 0);
          wr(2, m[7:0]); wr(3, m[15:8]); wr(1, 8'(em));
          wr(0, {1'b0, sw[0], 6'b000011});
          check("R1/R3 pgmAllow", pgmAllow, {NBLK{g}});
          check("R2 ersAllow", ersAllow, g ? m : '0);
          check("R1/R3 pgmActive", pgmActive, g);
          check("R2 ersActive", ersActive, g && (m != 0));
          rd(3, r); check("R2 mask readback", r, m[15:8]);
          wr(0, 8'h00);
        end

    // R10 events while gated off
    wr(1, 8'h00); wr(2, 8'h01); wr(0, 8'h03);   // mode bits set, swEn=0
    @(negedge clk); flashRd = 1'b1; excEntry = 1'b1; sleepEvt = 1'b1;
    #1 check("R10 no abort", abortReq, 0);
    @(negedge clk); flashRd = 1'b0; excEntry = 1'b0; sleepEvt = 1'b0;
    check("R10 no lock", errLock, 0);
    rd(0, r); check("R10 bits kept", r, 8'h03);

    // R4 R5 R6 R7 R8 R9 per event x mode
    for (int ev = 0; ev < 3; ev++)
      for (int md = 0; md < 2; md++) begin
        por();
        wr(2, 8'h0A); wr(3, 8'h80);
        wr(0, md == 0 ? 8'h45 : 8'h4A);   // swEn + mode + one verify bit
        check("R4 active before", md == 0 ? pgmActive : ersActive, 1);
        @(negedge clk);
        flashRd = (ev == 0); excEntry = (ev == 1); sleepEvt = (ev == 2);
        #1 check(ev == 0 ? "R4 abort same cycle" : "R5 abort same cycle", abortReq, 1);
        @(negedge clk); flashRd = 1'b0; excEntry = 1'b0; sleepEvt = 1'b0;
        check(ev == 0 ? "R4 lock set" : "R5 lock set", errLock, 1);
        rd(0, r);
        check("R6 ctrl after abort", r, md == 0 ? 8'hC4 : 8'hC8);
        rd(2, r); check("R6 mask kept", r, 8'h0A);
        check("R6 idle", {pgmActive, ersActive}, 0);
        wr(0, 8'h43);
        rd(0, r); check("R7 mode rewrite ignored", r, 8'hC0);
        check("R7 still idle", {pgmActive, ersActive, pgmAllow != 0}, 0);
        wr(0, 8'h4C);
        rd(0, r); check("R8 verify bits", r, 8'hCC);
        wr(0, 8'h00);
        check("R9 sw write keeps lock", errLock, 1);
        @(negedge clk); warmRst = 1'b1; @(negedge clk); warmRst = 1'b0;
        check("R9 warm keeps lock", errLock, 1);
        rd(3, r); check("R9 warm clears mask", r, 0);
        por();
        check("R9 por clears lock", errLock, 0);
        wr(0, 8'h41); check("R9 program again", pgmActive, 1);
      end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule